// File: doc/BRIEF.md
# Per-Bit Attribute Register Bank

This block is a bank of control and status registers on a simple synchronous bus. Every register has a set of masks fixed when the design is elaborated. The masks decide, bit by bit, whether a bit is read-only, cleared by writing a one, cleared by being read, reserved, or unimplemented. Each register also has its own reset value. A bus write is merged into the stored word through these masks and a per-bit write-enable mask. A bus read returns the stored word and then clears the bits that are flagged clear-on-read.

Hardware logic next to the bank can raise status bits through a set input for each bit. This input only acts on bits that are cleared by writing a one or by being read. Three one-cycle error pulses flag misuse from the bus side:
- an access to an address that holds no register;
- a write that would change a reserved bit;
- a write that puts a one into an unimplemented bit.

A reset request for each register reloads that register's reset value. The data width can be set to 8, 16, 32 or 64 bits.

Top module: `attr_reg_bank`

## Requirements
- R1: While `rst` is high, and after it falls, every register holds its reset value, `bus_rdata` is 0 and all three error outputs are 0.
- R2: On a write to a defined address, a bit keeps its old value if it is read-only, write-one-to-clear or reserved, or if its `bus_wmask` bit is 0. Every other bit takes the `bus_wdata` bit. Unimplemented bits are writable.
- R3: On a write, a write-one-to-clear bit whose `bus_wdata` bit is 1 becomes 0, whatever its `bus_wmask` bit is. A write-one-to-clear bit written with 0 keeps its value.
- R4: A read of a defined address returns the value stored before that cycle. After the read, the bits of that register that are flagged clear-on-read are 0.
- R5: `err_rsvd` is 1 for exactly the one cycle after a write to a defined address in which `bus_wdata` differs from the old stored value in any reserved bit position.
- R6: `err_unimp` is 1 for exactly the one cycle after a write to a defined address in which `bus_wdata` has a 1 in any unimplemented bit position.
- R7: When bit i of `soft_rst` is high at a clock edge, register i loads its reset value. This overrides a write, a clear and a hardware set in the same cycle.
- R8: An access to an address at or above NUM_REGS changes no register and raises `err_undef` for one cycle. A read of such an address returns 0.
- R9: A high `hw_set` bit sets its register bit if that bit is write-one-to-clear or clear-on-read. The set wins over a write-one or a read clear in the same cycle. On any other bit `hw_set` has no effect.
- R10: `bus_rdata` is registered. It shows the read result in the cycle after `bus_rd` and holds that value until the next read.
- R11: When a read and a write hit the same register in the same cycle, the read returns the pre-write value. The stored result is the write merge followed by the clear-on-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_wmask | input | DATA_W | Per-bit write enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| hw_set | input | NUM_REGS*DATA_W | Hardware status set, DATA_W bits per register, register 0 lowest |
| soft_rst | input | NUM_REGS | Reset request for each register |
| err_undef | output | 1 | Undefined-address access pulse |
| err_rsvd | output | 1 | Reserved-bit change pulse |
| err_unimp | output | 1 | Unimplemented-bit write pulse |

## Verification
The bench builds the bank with DATA_W=16, NUM_REGS=4 and ADDR_W=3, so half of the address space holds no register. This makes the undefined-address behaviour as easy to reach as a normal access. Each of the four registers is given one attribute class:
- register 0 is plain read/write with a nonzero reset value;
- register 1 mixes read-only, reserved and unimplemented fields;
- register 2 has write-one-to-clear bits;
- register 3 has clear-on-read bits.

With this layout, every merge rule and error condition can be seen through a single read. Random traffic with sparse hardware sets and rare register reset requests reaches the collisions between a set, a clear, a read and a write in the same cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned MAX_W = 64;

  // Merge a bus write into a stored word: protected bits keep the old value,
  // then write-one-to-clear bits seeing a one drop to zero.
  function automatic logic [MAX_W-1:0] write_merge(
    input logic [MAX_W-1:0] old_v,
    input logic [MAX_W-1:0] wdata,
    input logic [MAX_W-1:0] wmask,
    input logic [MAX_W-1:0] ro,
    input logic [MAX_W-1:0] w1c,
    input logic [MAX_W-1:0] rsvd
  );
    logic [MAX_W-1:0] keep;
    logic [MAX_W-1:0] v;
    keep = ro | w1c | rsvd | ~wmask;
    v    = (wdata & ~keep) | (old_v & keep);
    return v & ~(wdata & w1c);
  endfunction
endpackage

// File: rtl/attr_reg_cell.sv
module attr_reg_cell #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] RO      = '0,
  parameter logic [DATA_W-1:0] W1C     = '0,
  parameter logic [DATA_W-1:0] COR     = '0,
  parameter logic [DATA_W-1:0] RSVD    = '0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] value
);
  localparam logic [DATA_W-1:0] SETTABLE = W1C | COR;

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = value;
    if (wr_sel) begin
      nxt = DATA_W'(regbank_pkg::write_merge(
              64'(value), 64'(wdata), 64'(wmask),
              64'(RO), 64'(W1C), 64'(RSVD)));
    end
    if (rd_sel) begin
      nxt = nxt & ~COR;
    end
    nxt = nxt | (hw_set & SETTABLE);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) value <= RST_VAL;
    else                 value <= nxt;
  end
endmodule

// File: rtl/attr_access_check.sv
module attr_access_check #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 2,
  parameter logic [NUM_REGS*DATA_W-1:0] RSVD_MASK  = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] UNIMP_MASK = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [NUM_REGS*DATA_W-1:0] reg_state,
  output logic [NUM_REGS-1:0]        wr_sel,
  output logic [NUM_REGS-1:0]        rd_sel,
  output logic                       err_undef,
  output logic                       err_rsvd,
  output logic                       err_unimp
);
  logic [NUM_REGS-1:0] rsvd_hit;
  logic [NUM_REGS-1:0] unimp_hit;
  logic                hit_any;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [DATA_W-1:0] RS = RSVD_MASK[i*DATA_W +: DATA_W];
    localparam logic [DATA_W-1:0] UI = UNIMP_MASK[i*DATA_W +: DATA_W];
    logic addr_eq;
    assign addr_eq      = (bus_addr == ADDR_W'(i));
    assign wr_sel[i]    = bus_wr && addr_eq;
    assign rd_sel[i]    = bus_rd && addr_eq;
    assign rsvd_hit[i]  = wr_sel[i] &&
                          (|((reg_state[i*DATA_W +: DATA_W] ^ bus_wdata) & RS));
    assign unimp_hit[i] = wr_sel[i] && (|(bus_wdata & UI));
  end

  assign hit_any = |(wr_sel | rd_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_undef <= 1'b0;
      err_rsvd  <= 1'b0;
      err_unimp <= 1'b0;
    end else begin
      err_undef <= (bus_wr || bus_rd) && !hit_any;
      err_rsvd  <= |rsvd_hit;
      err_unimp <= |unimp_hit;
    end
  end
endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 2,
  parameter logic [NUM_REGS*DATA_W-1:0] RO_MASK    = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] W1C_MASK   = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] COR_MASK   = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] RSVD_MASK  = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] UNIMP_MASK = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VAL  = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [DATA_W-1:0]          bus_wmask,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_REGS*DATA_W-1:0] hw_set,
  input  logic [NUM_REGS-1:0]        soft_rst,
  output logic                       err_undef,
  output logic                       err_rsvd,
  output logic                       err_unimp
);
  localparam int unsigned BANK_W = NUM_REGS * DATA_W;

  if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : g_bad_w
    $error("DATA_W must be 8, 16, 32 or 64");
  end
  if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_a
    $error("ADDR_W too narrow for NUM_REGS");
  end

  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS-1:0] rd_sel;
  logic [BANK_W-1:0]   reg_state;
  logic [DATA_W-1:0]   rd_word;

  attr_access_check #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
    .RSVD_MASK(RSVD_MASK), .UNIMP_MASK(UNIMP_MASK)
  ) u_access (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .reg_state(reg_state),
    .wr_sel(wr_sel), .rd_sel(rd_sel),
    .err_undef(err_undef), .err_rsvd(err_rsvd), .err_unimp(err_unimp)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    attr_reg_cell #(
      .DATA_W (DATA_W),
      .RO     (RO_MASK  [i*DATA_W +: DATA_W]),
      .W1C    (W1C_MASK [i*DATA_W +: DATA_W]),
      .COR    (COR_MASK [i*DATA_W +: DATA_W]),
      .RSVD   (RSVD_MASK[i*DATA_W +: DATA_W]),
      .RST_VAL(RESET_VAL[i*DATA_W +: DATA_W])
    ) u_cell (
      .clk(clk), .rst(rst), .soft_rst(soft_rst[i]),
      .wr_sel(wr_sel[i]), .rd_sel(rd_sel[i]),
      .wdata(bus_wdata), .wmask(bus_wmask),
      .hw_set(hw_set[i*DATA_W +: DATA_W]),
      .value(reg_state[i*DATA_W +: DATA_W])
    );
  end

  // One-hot select OR-tree; an undefined address selects nothing and reads 0.
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel[i]) rd_word = rd_word | reg_state[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/attr_reg_bank_chk.sv
module attr_reg_bank_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 2,
  parameter logic [NUM_REGS*DATA_W-1:0] RO_MASK  = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] W1C_MASK = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] COR_MASK = '0
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_REGS*DATA_W-1:0] hw_set,
  input logic [NUM_REGS-1:0]        soft_rst,
  input logic [NUM_REGS*DATA_W-1:0] reg_state,
  input logic                       err_undef,
  input logic                       err_rsvd,
  input logic                       err_unimp
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);
  localparam logic [NUM_REGS*DATA_W-1:0] PURE_RO = RO_MASK & ~W1C_MASK & ~COR_MASK;

  logic undef_addr;
  assign undef_addr = ({1'b0, bus_addr} >= LIMIT);

  // R8: the undefined-access pulse follows an access to an unmapped address
  p_undef_flag_r8: assert property (@(posedge clk) disable iff (rst)
    err_undef |-> $past((bus_wr || bus_rd) && undef_addr));

  // R8: a read of an unmapped address returns zero
  p_undef_rdata_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && undef_addr) |=> (bus_rdata == '0));

  // R8: a write to an unmapped address leaves all registers alone
  p_undef_write_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && undef_addr && hw_set == '0 && soft_rst == '0) |=> $stable(reg_state));

  // R2: pure read-only bits only move through a register reset request
  p_ro_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (((reg_state ^ $past(reg_state)) & PURE_RO) != '0) |-> $past(soft_rst != '0));

  // R5: a reserved-bit pulse needs a write in the previous cycle
  p_rsvd_src_r5: assert property (@(posedge clk) disable iff (rst)
    err_rsvd |-> $past(bus_wr && !undef_addr));

  // R6: an unimplemented-bit pulse needs a write in the previous cycle
  p_unimp_src_r6: assert property (@(posedge clk) disable iff (rst)
    err_unimp |-> $past(bus_wr && !undef_addr));

  // R10: read data only changes after a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind attr_reg_bank attr_reg_bank_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
  .RO_MASK(RO_MASK), .W1C_MASK(W1C_MASK), .COR_MASK(COR_MASK)
) u_bank_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .hw_set(hw_set), .soft_rst(soft_rst),
  .reg_state(reg_state), .err_undef(err_undef), .err_rsvd(err_rsvd),
  .err_unimp(err_unimp)
);

// File: tb/tb_attr_reg_bank.sv
`timescale 1ns/1ps
module tb_attr_reg_bank;
  localparam int DW = 16;
  localparam int NR = 4;
  localparam int AW = 3;
  // register order in each constant: reg3, reg2, reg1, reg0
  localparam logic [63:0] M_RO    = 64'h0000_0000_F000_0000;
  localparam logic [63:0] M_W1C   = 64'h0000_00FF_0000_0000;
  localparam logic [63:0] M_COR   = 64'hFF00_0000_0000_0000;
  localparam logic [63:0] M_RSVD  = 64'h0000_0000_0F00_0000;
  localparam logic [63:0] M_UNIMP = 64'h0000_0000_00F0_0000;
  localparam logic [63:0] M_RST   = 64'h0000_0000_5A00_1234;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_wmask = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [63:0]   hw_set = '0;
  logic [NR-1:0] soft_rst = '0;
  logic          err_undef, err_rsvd, err_unimp;

  always #2 clk = ~clk;

  attr_reg_bank #(
    .DATA_W(DW), .NUM_REGS(NR), .ADDR_W(AW),
    .RO_MASK(M_RO), .W1C_MASK(M_W1C), .COR_MASK(M_COR),
    .RSVD_MASK(M_RSVD), .UNIMP_MASK(M_UNIMP), .RESET_VAL(M_RST)
  ) dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] model [NR];
  logic [DW-1:0] exp_rdata = '0;

  function automatic logic [DW-1:0] fld(input logic [63:0] m, input int i);
    return m[i*DW +: DW];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle, started at a falling edge, checked at the next falling edge.
  task automatic step(input bit wr, input bit rd, input int a,
                      input logic [DW-1:0] wd, input logic [DW-1:0] wm,
                      input logic [63:0] hw, input logic [NR-1:0] sr,
                      input string tag);
    bit defined;
    bit e_undef, e_rsvd, e_unimp;
    logic [DW-1:0] v, keep;
    defined = (a < NR);
    e_undef = (wr || rd) && !defined;
    e_rsvd  = wr && defined && (|((model[a] ^ wd) & fld(M_RSVD, a)));
    e_unimp = wr && defined && (|(wd & fld(M_UNIMP, a)));
    if (rd) exp_rdata = defined ? model[a] : '0;
    bus_wr = wr; bus_rd = rd; bus_addr = AW'(a);
    bus_wdata = wd; bus_wmask = wm; hw_set = hw; soft_rst = sr;
    @(negedge clk);
    check({tag, " rdata(R10)"}, 64'(bus_rdata), 64'(exp_rdata));
    check({tag, " undef(R8)"}, 64'(err_undef), 64'(e_undef));
    check({tag, " rsvd(R5)"},  64'(err_rsvd),  64'(e_rsvd));
    check({tag, " unimp(R6)"}, 64'(err_unimp), 64'(e_unimp));
    for (int i = 0; i < NR; i++) begin
      if (sr[i]) begin
        model[i] = fld(M_RST, i);
      end else begin
        v = model[i];
        if (wr && a == i) begin
          keep = fld(M_RO, i) | fld(M_W1C, i) | fld(M_RSVD, i) | ~wm;
          v = (wd & ~keep) | (v & keep);
          v = v & ~(wd & fld(M_W1C, i));
        end
        if (rd && a == i) v = v & ~fld(M_COR, i);
        v = v | (fld(hw, i) & (fld(M_W1C, i) | fld(M_COR, i)));
        model[i] = v;
      end
    end
    bus_wr = 1'b0; bus_rd = 1'b0; hw_set = '0; soft_rst = '0;
  endtask

  task automatic rd_reg(input int a, input string tag);
    step(0, 1, a, '0, '0, '0, '0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) model[i] = fld(M_RST, i);
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", 64'(bus_rdata), 64'h0);
    check("R1 errors in reset", 64'({err_undef, err_rsvd, err_unimp}), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 errors after reset", 64'({err_undef, err_rsvd, err_unimp}), 64'h0);
    for (int i = 0; i < NR; i++) rd_reg(i, "R1 reset value read R4");

    // R2: partial write mask on a plain register
    step(1, 0, 0, 16'hABCD, 16'h00FF, '0, '0, "R2 masked write");
    rd_reg(0, "R2 readback 12CD");
    check("R2 direct value", 64'(exp_rdata), 64'h12CD);
    // R2 R5 R6: read-only / reserved / unimplemented fields
    step(1, 0, 1, 16'hFFFF, 16'hFFFF, '0, '0, "R5 R6 R2 protected write");
    rd_reg(1, "R2 readback 5AFF");
    step(1, 0, 1, 16'h0A0F, 16'hFFFF, '0, '0, "R5 R6 quiet write");
    rd_reg(1, "R2 readback 5A0F");
    // R9 R3: hardware set, then write-one-to-clear with mask off and a colliding set
    step(0, 0, 0, '0, '0, 64'h0000_00F3_0000_0000, '0, "R9 hw set");
    rd_reg(2, "R9 readback 00F3");
    step(1, 0, 2, 16'h0003, 16'h0000, 64'h0000_0001_0000_0000, '0, "R3 R9 clear vs set");
    rd_reg(2, "R3 readback 00F1");
    step(0, 0, 0, '0, '0, 64'hFFFF_FF00_FFFF_FFFF, '0, "R9 set on non-status bits");
    rd_reg(0, "R9 plain reg untouched");
    rd_reg(2, "R9 w1c reg only low byte");
    // R4: clear on read
    step(1, 0, 3, 16'hFFFF, 16'hFFFF, '0, '0, "R4 fill");
    rd_reg(3, "R4 first read FFFF");
    rd_reg(3, "R4 second read 00FF");
    // R11: same-cycle read and write
    step(1, 1, 0, 16'h5555, 16'hFFFF, '0, '0, "R11 rd+wr old value");
    rd_reg(0, "R11 new value");
    step(1, 1, 3, 16'hAB00, 16'hFFFF, '0, '0, "R11 rd+wr cor");
    rd_reg(3, "R11 cor cleared after rd+wr");
    // R8: undefined address
    step(1, 1, 5, 16'hFFFF, 16'hFFFF, '0, '0, "R8 undefined rd+wr");
    step(1, 0, 7, 16'h0000, 16'hFFFF, '0, '0, "R8 undefined write");
    for (int i = 0; i < NR; i++) rd_reg(i, "R8 no register changed");
    // R7: register reset request beats write and set
    step(1, 0, 2, 16'h0000, 16'hFFFF, 64'h0000_00FF_0000_0000, 4'b0100, "R7 reset vs set");
    step(1, 0, 0, 16'hFFFF, 16'hFFFF, '0, 4'b0001, "R7 reset vs write");
    rd_reg(0, "R7 reg0 reset value");
    rd_reg(2, "R7 reg2 reset value");
    // R10: hold without read
    step(0, 0, 1, 16'h1111, 16'hFFFF, '0, '0, "R10 hold");

    for (int n = 0; n < 600; n++) begin
      bit wr, rd;
      int a;
      logic [63:0] hw;
      logic [NR-1:0] sr;
      wr = bit'($urandom % 2);
      rd = bit'($urandom % 2);
      a  = int'($urandom % 8);
      hw = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom % 4 != 0) hw = '0;
      sr = ($urandom % 20 == 0) ? NR'($urandom) : '0;
      step(wr, rd, a, DW'($urandom), DW'($urandom), hw, sr, "R2 R3 R4 R9 random");
    end
    for (int i = 0; i < NR; i++) rd_reg(i, "R4 final readback");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule